// File: doc/BRIEF.md
# Instruction Control Word Decoder

This block turns the operation code of a fixed-length 32-bit load/store instruction into the set of steering and enable signals a single-cycle datapath needs. It is purely combinational. The caller hands it the 6-bit opcode field. For register-register instructions it also passes the 6-bit function field. It returns eight one-bit controls and a 3-bit code for the arithmetic unit.

Six instruction classes are recognised: register-register arithmetic, or with an immediate, word load, word store, branch when equal, and unconditional jump. Any other opcode gives a harmless control word. In that word no register is written, memory is not written, and control flow does not change. The arithmetic code comes from two levels of decoding. The first level maps the opcode to a coarse operation. For register-register instructions the second level refines that operation from the function field. Every output whose value would not matter for a class is driven to 0, so the control word is fully determined.

Top module: `instr_ctrl_decode`

## Requirements
- R1: Opcode 000000 (register-register) gives reg_wr=1, dst_is_rd=1, and 0 on alu_b_imm, wb_from_mem, mem_wr, br_eq, jmp and imm_signed.
- R2: With opcode 000000, the function code sets alu_fn: 100000 gives ADD (000), 100010 gives SUB (001), 100100 gives AND (010), 100101 gives OR (011), and 101010 gives SLT (100).
- R3: With opcode 000000, any function code not listed in R2 gives alu_fn ADD (000).
- R4: Opcode 001101 (or-immediate) gives reg_wr=1, alu_b_imm=1 and alu_fn OR (011). All other one-bit outputs are 0, and imm_signed=0 selects zero extension.
- R5: Opcode 100011 (load word) gives reg_wr=1, alu_b_imm=1, wb_from_mem=1 and imm_signed=1 with alu_fn ADD. All other one-bit outputs are 0.
- R6: Opcode 101011 (store word) gives mem_wr=1, alu_b_imm=1 and imm_signed=1 with alu_fn ADD. All other one-bit outputs are 0.
- R7: Opcode 000100 (branch-equal) gives br_eq=1 and imm_signed=1 with alu_fn SUB. All other one-bit outputs are 0.
- R8: Opcode 000010 (jump) gives jmp=1. All other one-bit outputs are 0 and alu_fn is ADD.
- R9: Any opcode outside the six above gives all eight one-bit outputs 0 and alu_fn ADD.
- R10: For every opcode except 000000, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Operation code field of the instruction |
| funct_i | input | 6 | Function field; used only for register-register instructions |
| reg_wr_o | output | 1 | Register file write enable |
| alu_b_imm_o | output | 1 | Second ALU operand comes from the extended immediate |
| dst_is_rd_o | output | 1 | Destination register is taken from the rd field instead of the rt field |
| wb_from_mem_o | output | 1 | Write-back data comes from data memory instead of the ALU |
| mem_wr_o | output | 1 | Data memory write enable |
| br_eq_o | output | 1 | Branch is taken when the ALU reports equality |
| jmp_o | output | 1 | Unconditional jump |
| imm_signed_o | output | 1 | 1 selects sign extension of the 16-bit immediate, 0 selects zero extension |
| alu_fn_o | output | 3 | ALU operation: ADD 000, SUB 001, AND 010, OR 011, SLT 100 |

## Verification
The block holds no state, so a wrong entry in the class match or in the control table shows up at the ports in the same evaluation as the opcode that selects it. It shows as a wrong bit of the control word for that opcode and nowhere else. A fault in the second-level arithmetic decode shows only on register-register opcodes, and only for the affected function codes. The bench therefore sweeps every opcode, sweeps every function code under the register-register opcode, and applies random function fields under the other opcodes, comparing the full word each cycle.

// File: rtl/instr_ctrl_pkg.sv
package instr_ctrl_pkg;

  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int ALU_W  = 3;
  localparam int N_CLS  = 6;

  // Final ALU operation code seen by the arithmetic unit.
  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  // Coarse operation chosen from the opcode alone.
  typedef enum logic [2:0] {
    MOP_ADD  = 3'd0,
    MOP_SUB  = 3'd1,
    MOP_OR   = 3'd2,
    MOP_FUNC = 3'd4
  } main_op_e;

  // Class index, also the bit position inside the one-hot class vector.
  typedef enum int {
    CL_REG   = 0,
    CL_ORI   = 1,
    CL_LOAD  = 2,
    CL_STORE = 3,
    CL_BEQ   = 4,
    CL_JUMP  = 5
  } cls_idx_e;

  localparam logic [OP_W-1:0] CLS_OPCODE [N_CLS] = '{
    6'b000000, 6'b001101, 6'b100011, 6'b101011, 6'b000100, 6'b000010
  };

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic     reg_wr;
    logic     alu_b_imm;
    logic     dst_is_rd;
    logic     wb_from_mem;
    logic     mem_wr;
    logic     br_eq;
    logic     jmp;
    logic     imm_signed;
    main_op_e mop;
  } ctrl_word_t;

  localparam ctrl_word_t CTRL_IDLE = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                       1'b0, 1'b0, 1'b0, MOP_ADD};

  // Control word for one class; unused fields stay at 0.
  function automatic ctrl_word_t class_word(input int idx);
    ctrl_word_t w;
    w = CTRL_IDLE;
    case (idx)
      CL_REG:   begin w.reg_wr = 1'b1; w.dst_is_rd = 1'b1; w.mop = MOP_FUNC; end
      CL_ORI:   begin w.reg_wr = 1'b1; w.alu_b_imm = 1'b1; w.mop = MOP_OR; end
      CL_LOAD:  begin w.reg_wr = 1'b1; w.alu_b_imm = 1'b1; w.wb_from_mem = 1'b1;
                      w.imm_signed = 1'b1; end
      CL_STORE: begin w.mem_wr = 1'b1; w.alu_b_imm = 1'b1; w.imm_signed = 1'b1; end
      CL_BEQ:   begin w.br_eq = 1'b1; w.imm_signed = 1'b1; w.mop = MOP_SUB; end
      CL_JUMP:  begin w.jmp = 1'b1; end
      default:  w = CTRL_IDLE;
    endcase
    return w;
  endfunction

  // Second-level refinement of the ALU operation from the function field.
  function automatic alu_fn_e funct_to_alu(input logic [FN_W-1:0] fn);
    alu_fn_e r;
    case (fn)
      FN_SUB:  r = ALU_SUB;
      FN_AND:  r = ALU_AND;
      FN_OR:   r = ALU_OR;
      FN_SLT:  r = ALU_SLT;
      default: r = ALU_ADD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ctrl_class_match.sv
module ctrl_class_match
  import instr_ctrl_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  output logic [N_CLS-1:0] cls_hit_o,
  output logic             cls_none_o
);

  for (genvar g = 0; g < N_CLS; g++) begin : g_cls
    assign cls_hit_o[g] = (opcode_i == CLS_OPCODE[g]);
  end

  assign cls_none_o = ~|cls_hit_o;

  always_comb begin
    if (!$isunknown(opcode_i)) begin
      a_r9_class_onehot: assert ($onehot0(cls_hit_o))
        else $error("opcode matched more than one class");
    end
  end

endmodule

// File: rtl/ctrl_word_table.sv
module ctrl_word_table
  import instr_ctrl_pkg::*;
(
  input  logic [N_CLS-1:0] cls_hit_i,
  output ctrl_word_t       word_o
);

  ctrl_word_t per_cls [N_CLS];

  for (genvar g = 0; g < N_CLS; g++) begin : g_word
    assign per_cls[g] = cls_hit_i[g] ? class_word(g) : CTRL_IDLE;
  end

  // Classes are mutually exclusive, so an OR merge picks the one hit.
  always_comb begin
    word_o = CTRL_IDLE;
    for (int i = 0; i < N_CLS; i++) word_o = word_o | per_cls[i];
  end

  always_comb begin
    if (!$isunknown(cls_hit_i)) begin
      a_r6_store_no_regwr: assert (!(word_o.mem_wr && word_o.reg_wr))
        else $error("memory write together with register write");
      a_r5_memwb_needs_regwr: assert (!word_o.wb_from_mem || (word_o.reg_wr && word_o.alu_b_imm))
        else $error("memory write-back without register write");
    end
  end

endmodule

// File: rtl/ctrl_alu_select.sv
module ctrl_alu_select
  import instr_ctrl_pkg::*;
(
  input  main_op_e        mop_i,
  input  logic [FN_W-1:0] funct_i,
  output alu_fn_e         alu_fn_o
);

  logic use_funct;
  assign use_funct = (mop_i == MOP_FUNC);

  always_comb begin
    case (mop_i)
      MOP_SUB:  alu_fn_o = ALU_SUB;
      MOP_OR:   alu_fn_o = ALU_OR;
      MOP_FUNC: alu_fn_o = funct_to_alu(funct_i);
      default:  alu_fn_o = ALU_ADD;
    endcase
  end

  always_comb begin
    if (!$isunknown({mop_i, funct_i})) begin
      a_r7_sub_passthrough: assert (mop_i != MOP_SUB || alu_fn_o == ALU_SUB)
        else $error("coarse SUB not passed on");
      a_r10_funct_masked: assert (use_funct || alu_fn_o == ALU_ADD ||
                                  alu_fn_o == ALU_SUB || alu_fn_o == ALU_OR)
        else $error("function field leaked into non register-register op");
    end
  end

endmodule

// File: rtl/instr_ctrl_decode.sv
module instr_ctrl_decode
  import instr_ctrl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output logic       reg_wr_o,
  output logic       alu_b_imm_o,
  output logic       dst_is_rd_o,
  output logic       wb_from_mem_o,
  output logic       mem_wr_o,
  output logic       br_eq_o,
  output logic       jmp_o,
  output logic       imm_signed_o,
  output logic [2:0] alu_fn_o
);

  logic [N_CLS-1:0] cls_hit;
  logic             cls_none;
  ctrl_word_t       word;
  alu_fn_e          alu_fn;

  ctrl_class_match i_match (
    .opcode_i   (opcode_i),
    .cls_hit_o  (cls_hit),
    .cls_none_o (cls_none)
  );

  ctrl_word_table i_table (
    .cls_hit_i (cls_hit),
    .word_o    (word)
  );

  ctrl_alu_select i_alu (
    .mop_i    (word.mop),
    .funct_i  (funct_i),
    .alu_fn_o (alu_fn)
  );

  assign reg_wr_o      = word.reg_wr;
  assign alu_b_imm_o   = word.alu_b_imm;
  assign dst_is_rd_o   = word.dst_is_rd;
  assign wb_from_mem_o = word.wb_from_mem;
  assign mem_wr_o      = word.mem_wr;
  assign br_eq_o       = word.br_eq;
  assign jmp_o         = word.jmp;
  assign imm_signed_o  = word.imm_signed;
  assign alu_fn_o      = alu_fn;

  always_comb begin
    if (!$isunknown({opcode_i, funct_i})) begin
      a_r9_unknown_idle: assert (!cls_none ||
        ({reg_wr_o, alu_b_imm_o, dst_is_rd_o, wb_from_mem_o, mem_wr_o,
          br_eq_o, jmp_o, imm_signed_o} == 8'b0 && alu_fn_o == ALU_ADD))
        else $error("unrecognised opcode produced active control");
      a_r8_jump_quiet: assert (!jmp_o || !(reg_wr_o || mem_wr_o || br_eq_o))
        else $error("jump with side effects");
      a_r1_rd_only_regreg: assert (!dst_is_rd_o || (opcode_i == 6'b000000 && reg_wr_o))
        else $error("rd destination outside register-register class");
    end
  end

endmodule

// File: tb/test_instr_ctrl_decode.sv
module test_instr_ctrl_decode;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [5:0] funct  = 6'b100000;
  logic       reg_wr, alu_b_imm, dst_is_rd, wb_from_mem, mem_wr, br_eq, jmp, imm_signed;
  logic [2:0] alu_fn;
  int         total = 0;
  int         bad = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  instr_ctrl_decode i_instr_ctrl_decode (
    .opcode_i(opcode), .funct_i(funct),
    .reg_wr_o(reg_wr), .alu_b_imm_o(alu_b_imm), .dst_is_rd_o(dst_is_rd),
    .wb_from_mem_o(wb_from_mem), .mem_wr_o(mem_wr), .br_eq_o(br_eq),
    .jmp_o(jmp), .imm_signed_o(imm_signed), .alu_fn_o(alu_fn)
  );

  // Reference: {regwr, imm_b, rd_dst, mem_wb, mem_wr, beq, jmp, sext, alu[2:0]}
  function automatic logic [10:0] model(input logic [5:0] op, input logic [5:0] fn);
    logic [2:0] a;
    if (op == 6'd0) begin
      if (fn == 6'd34) a = 3'd1;
      else if (fn == 6'd36) a = 3'd2;
      else if (fn == 6'd37) a = 3'd3;
      else if (fn == 6'd42) a = 3'd4;
      else a = 3'd0;
      return {8'b1010_0000, a};
    end
    if (op == 6'd13) return {8'b1100_0000, 3'd3};
    if (op == 6'd35) return {8'b1101_0001, 3'd0};
    if (op == 6'd43) return {8'b0100_1001, 3'd0};
    if (op == 6'd4)  return {8'b0000_0101, 3'd1};
    if (op == 6'd2)  return {8'b0000_0010, 3'd0};
    return 11'd0;
  endfunction

  function automatic string tag(input logic [5:0] op, input logic [5:0] fn);
    if (op == 6'd0)
      return (fn inside {6'd32, 6'd34, 6'd36, 6'd37, 6'd42}) ? "R1 R2" : "R1 R3";
    case (op)
      6'd13: return "R4";
      6'd35: return "R5";
      6'd43: return "R6";
      6'd4:  return "R7";
      6'd2:  return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input string t);
    logic [10:0] got, exp;
    @(posedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
    got = {reg_wr, alu_b_imm, dst_is_rd, wb_from_mem, mem_wr, br_eq, jmp,
           imm_signed, alu_fn};
    exp = model(op, fn);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", t, op, fn, got, exp);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Value seen while reset is held: register-register add (R1).
    @(negedge clk);
    total++;
    if ({reg_wr, dst_is_rd, alu_fn} !== 5'b11000) begin
      bad++;
      $display("FAIL R1 reset-state actual=%b expected=11000", {reg_wr, dst_is_rd, alu_fn});
    end
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Every opcode with an add function field (R1, R4 to R9).
    for (int o = 0; o < 64; o++) apply(6'(o), 6'b100000, tag(6'(o), 6'b100000));
    // Every function code under the register-register opcode (R2, R3).
    for (int f = 0; f < 64; f++) apply(6'd0, 6'(f), tag(6'd0, 6'(f)));
    // Random function fields under the other opcodes must change nothing (R10).
    for (int k = 0; k < 96; k++) begin
      logic [5:0] op;
      logic [5:0] fn;
      op = (k % 2 == 0) ? 6'($urandom_range(1, 63)) :
           ((k % 4 == 1) ? 6'd13 : 6'd4);
      fn = 6'($urandom);
      apply(op, fn, "R10");
    end
    // Function codes that sit next to the decoded ones (R3).
    apply(6'd0, 6'b100001, "R3");
    apply(6'd0, 6'b101011, "R3");
    apply(6'd0, 6'b000000, "R3");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule